// File: doc/BRIEF.md
# Endian-Selectable Output Bus Unpacker

This block sits between the read side of a 36-bit wide FIFO and a narrower 18-bit output port. Each FIFO entry is split into pieces and handed to the port one piece per read. In word mode an entry leaves as two 18-bit halves. In byte mode it leaves as four 9-bit bytes, placed in the low nine bits of the port.

Two settings are taken from input pins while the synchronous reset is asserted and are then held for the rest of operation: the piece size and the piece order. With big-endian order the most significant piece of an entry comes out first. With little-endian order the least significant piece comes out first. The block pulls the next entry from the FIFO only after the last piece of the current entry has been read, and it raises an output-valid indicator while a piece is waiting.

Top module: `bus_unpacker`

## Requirements
- R1: The size select (`size_byte_i`: 1 = byte, 0 = word) and the order select (`big_endian_i`: 1 = most significant piece first, 0 = least significant first) are captured on clock edges while `rst_i` is high. Changing these pins after reset has no effect on the pieces delivered.
- R2: In word mode each entry is delivered as two 18-bit reads. Little-endian gives bits 17:0 and then bits 35:18. Big-endian gives bits 35:18 and then bits 17:0.
- R3: In byte mode each entry is delivered as four reads of 9 bits, placed on `dout_o[8:0]`, with `dout_o[17:9]` held at zero. Little-endian order is bits 8:0, 17:9, 26:18, 35:27. Big-endian order is the reverse.
- R4: A read happens only on a rising clock edge with `cs_n_i` low, `rd_en_i` high and `dout_valid_o` high. The piece appears on `dout_o` after that edge. In every other cycle `dout_o` and the position within the entry stay unchanged.
- R5: Reset clears `dout_o` to all zeros and drives `dout_valid_o` low.
- R6: `fifo_rd_o` pops one entry only when the FIFO is not empty and no piece of the current entry remains, counting the last piece being read in that cycle. Every entry written to the FIFO is popped exactly once.
- R7: `dout_valid_o` is high one cycle after an entry is popped, stays high while pieces remain, and is low when the FIFO is empty and no piece of an entry remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; the mode pins are sampled while it is high |
| size_byte_i | input | 1 | Piece size select: 1 = 9-bit bytes, 0 = 18-bit words |
| big_endian_i | input | 1 | Order select: 1 = most significant piece first |
| fifo_data_i | input | 36 | Entry at the head of the FIFO (show-ahead) |
| fifo_empty_i | input | 1 | FIFO holds no entries |
| fifo_rd_o | output | 1 | Pops the head entry on this clock edge |
| cs_n_i | input | 1 | Chip select, active low |
| rd_en_i | input | 1 | Read enable, active high |
| dout_o | output | 18 | Registered output piece |
| dout_valid_o | output | 1 | A piece is available for the next read |

## Verification
The embedded assertions check the following on every cycle: the output stays unchanged when no read is qualified, the upper nine bits stay zero in byte mode, the output is cleared after reset, the valid indicator comes up after a pop and stays up until the entry is used, and a pop restarts the piece position. The order of the pieces, the ignoring of the mode pins after reset, and the one-pop-per-entry accounting can only be seen in the bench scenarios. Those scenarios compare each delivered piece with a sequence built from the pushed entries under all four size and order settings, with random gaps on both sides.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

  typedef struct packed {
    logic byte_mode;
    logic big_end;
  } unpk_cfg_t;

endpackage

// File: rtl/unpk_cfg.sv
module unpk_cfg
  import unpk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      size_byte_i,
  input  logic      big_endian_i,
  output unpk_cfg_t cfg_o
);

  unpk_cfg_t cfg_q;

  // Mode pins are only looked at while reset is held.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q.byte_mode <= size_byte_i;
      cfg_q.big_end   <= big_endian_i;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/unpk_hold.sv
module unpk_hold #(
  parameter int ENTRY_W     = 36,
  parameter int WORD_PIECES = 2,
  parameter int BYTE_PIECES = 4,
  parameter int IDX_W       = 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               byte_mode_i,
  input  logic [ENTRY_W-1:0] fifo_data_i,
  input  logic               fifo_empty_i,
  output logic               fifo_rd_o,
  input  logic               req_i,
  output logic [ENTRY_W-1:0] hold_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               valid_o,
  output logic               take_o
);

  logic [ENTRY_W-1:0] hold_q;
  logic [IDX_W-1:0]   idx_q;
  logic               valid_q;
  logic               take;
  logic               last;
  logic               free;
  logic               pop;

  assign take = req_i && valid_q;
  assign last = byte_mode_i ? (idx_q == IDX_W'(BYTE_PIECES - 1))
                            : (idx_q == IDX_W'(WORD_PIECES - 1));
  assign free = !valid_q || (take && last);
  assign pop  = !rst_i && !fifo_empty_i && free;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (pop) begin
      hold_q  <= fifo_data_i;
      idx_q   <= '0;
      valid_q <= 1'b1;
    end else if (take) begin
      if (last) begin
        idx_q   <= '0;
        valid_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign fifo_rd_o = pop;
  assign hold_o    = hold_q;
  assign idx_o     = idx_q;
  assign valid_o   = valid_q;
  assign take_o    = take;

  AST_POP_RESTARTS: assert property (@(posedge clk_i) disable iff (rst_i)
    pop |=> (valid_q && idx_q == '0)); // R6

  AST_PENDING_KEEPS_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_q && !take) |=> valid_q); // R7

  AST_EMPTY_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!valid_q && fifo_empty_i) |=> !valid_q); // R7

endmodule

// File: rtl/unpk_slice.sv
module unpk_slice
  import unpk_pkg::*;
#(
  parameter int ENTRY_W     = 36,
  parameter int PORT_W      = 18,
  parameter int BYTE_W      = 9,
  parameter int WORD_PIECES = 2,
  parameter int BYTE_PIECES = 4,
  parameter int IDX_W       = 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  unpk_cfg_t          cfg_i,
  input  logic [ENTRY_W-1:0] hold_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               take_i,
  output logic [PORT_W-1:0]  dout_o
);

  localparam int WIDX_W = (WORD_PIECES > 1) ? $clog2(WORD_PIECES) : 1;
  localparam int PAD_W  = PORT_W - BYTE_W;

  logic [PORT_W-1:0] word_sl [WORD_PIECES];
  logic [BYTE_W-1:0] byte_sl [BYTE_PIECES];

  for (genvar g = 0; g < WORD_PIECES; g++) begin : g_word
    assign word_sl[g] = hold_i[g*PORT_W +: PORT_W];
  end

  for (genvar g = 0; g < BYTE_PIECES; g++) begin : g_byte
    assign byte_sl[g] = hold_i[g*BYTE_W +: BYTE_W];
  end

  logic [WIDX_W-1:0] slot_w;
  logic [IDX_W-1:0]  slot_b;
  logic [PORT_W-1:0] nxt;

  always_comb begin
    slot_w = cfg_i.big_end ? (WIDX_W'(WORD_PIECES - 1) - idx_i[WIDX_W-1:0])
                           : idx_i[WIDX_W-1:0];
    slot_b = cfg_i.big_end ? (IDX_W'(BYTE_PIECES - 1) - idx_i) : idx_i;
    if (cfg_i.byte_mode) nxt = {{PAD_W{1'b0}}, byte_sl[slot_b]};
    else                 nxt = word_sl[slot_w];
  end

  logic [PORT_W-1:0] dout_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       dout_q <= '0;
    else if (take_i) dout_q <= nxt;
  end

  assign dout_o = dout_q;

  AST_BYTE_TOP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    cfg_i.byte_mode |-> (dout_q[PORT_W-1:BYTE_W] == '0)); // R3

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    $past(rst_i) |-> (dout_q == '0)); // R5

endmodule

// File: rtl/bus_unpacker.sv
module bus_unpacker
  import unpk_pkg::*;
#(
  parameter int ENTRY_W = 36,
  parameter int PORT_W  = 18
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               size_byte_i,
  input  logic               big_endian_i,
  input  logic [ENTRY_W-1:0] fifo_data_i,
  input  logic               fifo_empty_i,
  output logic               fifo_rd_o,
  input  logic               cs_n_i,
  input  logic               rd_en_i,
  output logic [PORT_W-1:0]  dout_o,
  output logic               dout_valid_o
);

  localparam int BYTE_W      = PORT_W / 2;
  localparam int WORD_PIECES = ENTRY_W / PORT_W;
  localparam int BYTE_PIECES = ENTRY_W / BYTE_W;
  localparam int IDX_W       = $clog2(BYTE_PIECES);

  unpk_cfg_t          cfg;
  logic [ENTRY_W-1:0] hold;
  logic [IDX_W-1:0]   idx;
  logic               take;
  logic               req;

  assign req = !cs_n_i && rd_en_i;

  unpk_cfg i_cfg (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .size_byte_i (size_byte_i),
    .big_endian_i(big_endian_i),
    .cfg_o       (cfg)
  );

  unpk_hold #(
    .ENTRY_W    (ENTRY_W),
    .WORD_PIECES(WORD_PIECES),
    .BYTE_PIECES(BYTE_PIECES),
    .IDX_W      (IDX_W)
  ) i_hold (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .byte_mode_i (cfg.byte_mode),
    .fifo_data_i (fifo_data_i),
    .fifo_empty_i(fifo_empty_i),
    .fifo_rd_o   (fifo_rd_o),
    .req_i       (req),
    .hold_o      (hold),
    .idx_o       (idx),
    .valid_o     (dout_valid_o),
    .take_o      (take)
  );

  unpk_slice #(
    .ENTRY_W    (ENTRY_W),
    .PORT_W     (PORT_W),
    .BYTE_W     (BYTE_W),
    .WORD_PIECES(WORD_PIECES),
    .BYTE_PIECES(BYTE_PIECES),
    .IDX_W      (IDX_W)
  ) i_slice (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .cfg_i (cfg),
    .hold_i(hold),
    .idx_i (idx),
    .take_i(take),
    .dout_o(dout_o)
  );

  AST_IDLE_HOLDS_OUTPUT: assert property (@(posedge clk_i) disable iff (rst_i)
    !(!cs_n_i && rd_en_i && dout_valid_o) |=> $stable(dout_o)); // R4

  AST_POP_GIVES_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
    fifo_rd_o |=> dout_valid_o); // R7

endmodule

// File: tb/test_bus_unpacker.sv
module test_bus_unpacker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        size_byte = 1'b0;
  logic        big_end = 1'b0;
  logic [35:0] fifo_data;
  logic        fifo_empty;
  logic        fifo_rd;
  logic        cs_n = 1'b1;
  logic        rd_en = 1'b0;
  logic [17:0] dout;
  logic        dout_valid;

  always #2 clk = ~clk;

  logic [35:0] mem [256];
  int wp = 0;
  int rp = 0;
  int pops = 0;
  int pushes = 0;

  assign fifo_empty = (rp == wp);
  assign fifo_data  = mem[rp % 256];

  always @(posedge clk) begin
    if (fifo_rd) begin
      rp   <= rp + 1;
      pops <= pops + 1;
    end
  end

  bus_unpacker i_bus_unpacker (
    .clk_i       (clk),
    .rst_i       (rst),
    .size_byte_i (size_byte),
    .big_endian_i(big_end),
    .fifo_data_i (fifo_data),
    .fifo_empty_i(fifo_empty),
    .fifo_rd_o   (fifo_rd),
    .cs_n_i      (cs_n),
    .rd_en_i     (rd_en),
    .dout_o      (dout),
    .dout_valid_o(dout_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit          m_byte;
  bit          m_big;
  logic [17:0] pcs [1024];
  int          n_pc;
  int          n_del;
  logic [17:0] exp_dout;
  string       exp_tag;

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] piece_of(input logic [35:0] w, input int k, input bit byt, input bit big);
    int s;
    if (byt) begin
      s = big ? 3 - k : k;
      return {9'b0, w[9*s +: 9]};
    end
    s = big ? 1 - k : k;
    return w[18*s +: 18];
  endfunction

  // One cycle: check at the falling edge, then drive the next inputs.
  task automatic step(input bit cs, input bit ren, input bit push, input logic [35:0] w);
    bit ev;
    @(negedge clk);
    ev = (n_pc > n_del);
    chk(dout_valid == ev, "R7 valid", 36'(dout_valid), 36'(ev));
    chk(dout == exp_dout, exp_tag, 36'(dout), 36'(exp_dout));
    cs_n  = cs;
    rd_en = ren;
    if (ev && !cs && ren) begin
      exp_dout = pcs[n_del];
      n_del++;
      exp_tag = m_byte ? "R3 R1 byte piece" : "R2 R1 word piece";
    end else begin
      exp_tag = "R4 hold when no read";
    end
    if (push) begin
      mem[wp % 256] = w;
      wp++;
      pushes++;
      for (int k = 0; k < (m_byte ? 4 : 2); k++) begin
        pcs[n_pc] = piece_of(w, k, m_byte, m_big);
        n_pc++;
      end
    end
  endtask

  task automatic do_reset(input bit byt, input bit big);
    @(negedge clk);
    rst = 1'b1;
    cs_n = 1'b1;
    rd_en = 1'b0;
    size_byte = byt;
    big_end = big;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R5: output register cleared by reset
    chk(dout == 18'h0, "R5 dout after reset", 36'(dout), 36'h0);
    chk(dout_valid == 1'b0, "R5 valid after reset", 36'(dout_valid), 36'h0);
    // R1: flip the mode pins; latched settings must stay in force
    size_byte = ~byt;
    big_end = ~big;
    m_byte = byt;
    m_big = big;
    n_pc = 0;
    n_del = 0;
    exp_dout = 18'h0;
    exp_tag = "R5 dout zero";
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && n_del < n_pc; i++) step(1'b0, 1'b1, 1'b0, 36'h0);
    step(1'b1, 1'b0, 1'b0, 36'h0);
    chk(pops == pushes, "R6 pops equal pushes", 36'(pops), 36'(pushes));
  endtask

  task automatic run_phase(input bit byt, input bit big);
    int np;
    do_reset(byt, big);
    // Reads with nothing stored are ignored (R4, R7)
    repeat (3) step(1'b0, 1'b1, 1'b0, 36'h0);
    // Directed entries pushed before any read
    step(1'b1, 1'b0, 1'b1, 36'h1_2345_6789);
    step(1'b1, 1'b0, 1'b1, 36'hF_EDCB_A987);
    step(1'b1, 1'b0, 1'b1, 36'h8_0000_0001);
    repeat (4) step(1'b1, 1'b0, 1'b0, 36'h0);
    // Read enable high but chip select high: no read (R4)
    repeat (3) step(1'b1, 1'b1, 1'b0, 36'h0);
    drain();
    // Back-to-back reads while entries keep arriving
    step(1'b0, 1'b1, 1'b1, 36'hA_AAAA_5555);
    step(1'b0, 1'b1, 1'b1, 36'h0_1FF0_3FE1);
    drain();
    // Random traffic
    np = 0;
    for (int i = 0; i < 500; i++) begin
      bit cs;
      bit ren;
      bit push;
      logic [35:0] w;
      cs   = ($urandom % 4) == 0;
      ren  = ($urandom % 4) != 0;
      push = (($urandom % 3) == 0) && (np < 120);
      w    = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      if (push) np++;
      step(cs, ren, push, w);
    end
    drain();
  endtask

  initial begin
    void'($urandom(32'd4242));
    run_phase(1'b0, 1'b0);
    run_phase(1'b0, 1'b1);
    run_phase(1'b1, 1'b0);
    run_phase(1'b1, 1'b1);
    // Reset from a nonzero output clears it (R5)
    step(1'b1, 1'b0, 1'b1, 36'h7_7777_7777);
    drain();
    do_reset(1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0, 36'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule